// File: doc/BRIEF.md
# Ordered Miss and Write-Back Issue Arbiter

This block sits between a data cache's request side and the next memory level. It keeps two slot queues. The read queue takes cacheable misses and uncacheable reads. The write queue takes uncacheable writes and dirty-line evictions. Each accepted request receives the next value of a wrapping order counter. Cacheable requests to a line that already has a pending read-queue entry are folded into that entry, so that a single lower-level access serves all of them.

Each cycle the arbiter offers at most one entry to lower memory on a valid/ready port. Within a queue, entries leave by age. Between the two queues, reads go first unless the write queue is full. An entry never leaves ahead of an older, not yet issued entry in the other queue that targets the same line. A slot is released only when lower memory returns a completion that carries the slot's queue and index. The full flags and the per-line merge-cap flag tell the cache when it must refuse the CPU.

Top module: `mwb_issue_arb`

## Requirements
- R1: Each accepted request takes the current order counter value, which is 0 after reset and rises by one per accepted request, wrapping at 2^ORD_W. A refused request consumes no number. An entry reports the number of its first request on `iss_ord`.
- R2: A cacheable non-eviction request whose line matches an unissued cacheable read-queue entry is merged into that entry. `iss_cnt` gives the number of requests folded in. `iss_excl` is 1 if any of them was a write. A request that arrives after its line's entry has issued opens a new entry.
- R3: Within one queue, unissued entries are offered strictly from the lowest order number upward.
- R4: When both queues can issue, the read queue wins unless `wb_full` is 1, in which case the write queue wins.
- R5: An entry is not offered while the other queue holds an unissued entry on the same line with an older order number.
- R6: `iss_size` is LINE_BYTES for cacheable requests and evictions, and `req_size` for uncacheable reads and writes.
- R7: A cacheable request that matches an entry already holding MERGE_MAX requests raises `line_block` in the same cycle and is refused.
- R8: `miss_full` or `wb_full` is 1 when every slot of that queue is occupied. A new-entry request to a full queue is refused and never issues.
- R9: A slot stays occupied after issue, and its full flag stays set, until a completion arrives with `cpl_wb` selecting the queue (0 read, 1 write) and `cpl_slot` equal to the `iss_slot` seen at issue.
- R10: After reset, `iss_valid`, `miss_full`, `wb_full` and `line_block` are 0. The write queue receives requests with `req_evict`=1, or with `req_wr`=1 and `req_cach`=0. Its issues show `iss_wb`=1, `iss_cnt`=1 and `iss_excl`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU-side request present this cycle |
| req_line | input | LINE_W | Line address of the request |
| req_cach | input | 1 | Request targets cacheable memory |
| req_wr | input | 1 | Request is a write |
| req_evict | input | 1 | Request is a dirty-line write-back |
| req_size | input | SIZE_W | Byte count for uncacheable accesses |
| miss_full | output | 1 | Every read-queue slot occupied |
| wb_full | output | 1 | Every write-queue slot occupied |
| line_block | output | 1 | Current request hits a line at its merge cap |
| iss_valid | output | 1 | An entry is offered to lower memory |
| iss_ready | input | 1 | Lower memory takes the offered entry |
| iss_wb | output | 1 | Offered entry comes from the write queue |
| iss_slot | output | SLOT_W | Slot index of the offered entry |
| iss_line | output | LINE_W | Line address of the offered entry |
| iss_size | output | SIZE_W | Access size in bytes |
| iss_ord | output | ORD_W | Order number of the entry |
| iss_cnt | output | CNT_W | Requests folded into the entry |
| iss_excl | output | 1 | Entry contains a write |
| cpl_valid | input | 1 | Lower memory finished an entry |
| cpl_wb | input | 1 | Queue of the finished entry |
| cpl_slot | input | SLOT_W | Slot of the finished entry |

## Verification
The hardest case to reach is the same-line hazard acting against the read-first rule. Stimulus holds `iss_ready` low while it fills the write queue with a younger same-line write. The older read must then still go first, even though the full write queue would otherwise win. The mirror case, where an older write blocks a same-line cacheable read while the write queue has room, is built the same way. Merge depth is swept from one request to one past the cap, and the access size is swept over every byte count for both memory kinds.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
   // Wrapping age compare: 1 when a is older than b in a w-bit sequence space.
   function automatic logic ord_older(input logic [31:0] a, input logic [31:0] b, input int w);
      logic [31:0] d;
      d = (a - b) << (32 - w);
      return d[31];
   endfunction
endpackage

// File: rtl/mwb_slotq.sv
module mwb_slotq
   import mwb_pkg::*;
#(
   parameter int DEPTH     = 4,
   parameter int LINE_W    = 8,
   parameter int ORD_W     = 8,
   parameter int SIZE_W    = 4,
   parameter int MERGE_MAX = 4,
   parameter bit MERGE_EN  = 1'b1,
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int CNT_W    = $clog2(MERGE_MAX + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [LINE_W-1:0]             lk_line,
   input  logic                          lk_cach,
   output logic                          mg_ok,
   output logic                          mg_cap,
   input  logic                          push,
   input  logic [LINE_W-1:0]             push_line,
   input  logic [ORD_W-1:0]              push_ord,
   input  logic [SIZE_W-1:0]             push_size,
   input  logic                          push_cach,
   input  logic                          push_wr,
   input  logic                          pop,
   input  logic                          free,
   input  logic [IDX_W-1:0]              free_slot,
   output logic                          full,
   output logic                          head_vld,
   output logic [IDX_W-1:0]              head_slot,
   output logic [LINE_W-1:0]             head_line,
   output logic [ORD_W-1:0]              head_ord,
   output logic [SIZE_W-1:0]             head_size,
   output logic                          head_excl,
   output logic [CNT_W-1:0]              head_cnt,
   output logic [DEPTH-1:0]              live,
   output logic [DEPTH-1:0][LINE_W-1:0]  live_line,
   output logic [DEPTH-1:0][ORD_W-1:0]   live_ord
);
   if (DEPTH < 2)     begin : g_bad_depth $error("slot queue depth must be at least 2"); end
   if (MERGE_MAX < 1) begin : g_bad_merge $error("merge limit must be at least 1"); end

   logic [DEPTH-1:0]              vld_q, iss_q, cach_q, excl_q;
   logic [DEPTH-1:0][LINE_W-1:0]  line_q;
   logic [DEPTH-1:0][ORD_W-1:0]   ord_q;
   logic [DEPTH-1:0][SIZE_W-1:0]  size_q;
   logic [DEPTH-1:0][CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]              mg_slot, alloc_slot;

   assign full      = &vld_q;
   assign live      = vld_q & ~iss_q;
   assign live_line = line_q;
   assign live_ord  = ord_q;

   // oldest unissued entry
   always_comb begin
      head_vld  = 1'b0;
      head_slot = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (live[i] && (!head_vld ||
             ord_older(32'(ord_q[i]), 32'(ord_q[head_slot]), ORD_W))) begin
            head_vld  = 1'b1;
            head_slot = IDX_W'(i);
         end
      end
   end
   assign head_line = line_q[head_slot];
   assign head_ord  = ord_q[head_slot];
   assign head_size = size_q[head_slot];
   assign head_excl = excl_q[head_slot];
   assign head_cnt  = cnt_q[head_slot];

   always_comb begin
      alloc_slot = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!vld_q[i]) alloc_slot = IDX_W'(i);
      end
   end

   if (MERGE_EN) begin : g_merge
      logic hit;
      always_comb begin
         hit     = 1'b0;
         mg_slot = '0;
         for (int i = 0; i < DEPTH; i++) begin
            if (live[i] && cach_q[i] && lk_cach && line_q[i] == lk_line &&
                !(pop && head_slot == IDX_W'(i))) begin
               hit     = 1'b1;
               mg_slot = IDX_W'(i);
            end
         end
      end
      assign mg_ok  = hit && (cnt_q[mg_slot] < CNT_W'(MERGE_MAX));
      assign mg_cap = hit && (cnt_q[mg_slot] == CNT_W'(MERGE_MAX));
   end else begin : g_nomerge
      assign mg_slot = '0;
      assign mg_ok   = 1'b0;
      assign mg_cap  = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         iss_q <= '0;
      end else begin
         if (free) vld_q[free_slot] <= 1'b0;
         if (pop)  iss_q[head_slot] <= 1'b1;
         if (push) begin
            if (mg_ok) begin
               cnt_q[mg_slot]  <= cnt_q[mg_slot] + CNT_W'(1);
               excl_q[mg_slot] <= excl_q[mg_slot] | push_wr;
            end else begin
               vld_q[alloc_slot]  <= 1'b1;
               iss_q[alloc_slot]  <= 1'b0;
               line_q[alloc_slot] <= push_line;
               ord_q[alloc_slot]  <= push_ord;
               size_q[alloc_slot] <= push_size;
               cach_q[alloc_slot] <= push_cach;
               excl_q[alloc_slot] <= push_wr;
               cnt_q[alloc_slot]  <= CNT_W'(1);
            end
         end
      end
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && !mg_ok |-> !full);
   // R9
   free_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free |-> vld_q[free_slot] && iss_q[free_slot]);
   // R3
   pop_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_vld);
   // R7
   merge_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && mg_ok |=> cnt_q[$past(mg_slot)] <= CNT_W'(MERGE_MAX));
endmodule

// File: rtl/mwb_pick.sv
module mwb_pick
   import mwb_pkg::*;
#(
   parameter int M_DEPTH = 4,
   parameter int W_DEPTH = 4,
   parameter int LINE_W  = 8,
   parameter int ORD_W   = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            m_head_vld,
   input  logic [LINE_W-1:0]               m_head_line,
   input  logic [ORD_W-1:0]                m_head_ord,
   input  logic [M_DEPTH-1:0]              m_live,
   input  logic [M_DEPTH-1:0][LINE_W-1:0]  m_live_line,
   input  logic [M_DEPTH-1:0][ORD_W-1:0]   m_live_ord,
   input  logic                            w_head_vld,
   input  logic [LINE_W-1:0]               w_head_line,
   input  logic [ORD_W-1:0]                w_head_ord,
   input  logic [W_DEPTH-1:0]              w_live,
   input  logic [W_DEPTH-1:0][LINE_W-1:0]  w_live_line,
   input  logic [W_DEPTH-1:0][ORD_W-1:0]   w_live_ord,
   input  logic                            w_full,
   output logic                            sel_vld,
   output logic                            sel_wb
);
   logic m_haz, w_haz, m_go, w_go;

   always_comb begin
      m_haz = 1'b0;
      for (int j = 0; j < W_DEPTH; j++) begin
         if (w_live[j] && w_live_line[j] == m_head_line &&
             ord_older(32'(w_live_ord[j]), 32'(m_head_ord), ORD_W)) m_haz = 1'b1;
      end
      w_haz = 1'b0;
      for (int j = 0; j < M_DEPTH; j++) begin
         if (m_live[j] && m_live_line[j] == w_head_line &&
             ord_older(32'(m_live_ord[j]), 32'(w_head_ord), ORD_W)) w_haz = 1'b1;
      end
   end

   assign m_go    = m_head_vld && !m_haz;
   assign w_go    = w_head_vld && !w_haz;
   assign sel_vld = m_go || w_go;
   assign sel_wb  = w_go && (!m_go || w_full);

   // R4
   read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_go && w_go && !w_full |-> sel_vld && !sel_wb);
   // R5
   head_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_vld && !sel_wb && w_head_vld && w_head_line == m_head_line
      |-> ord_older(32'(m_head_ord), 32'(w_head_ord), ORD_W));
endmodule

// File: rtl/mwb_issue_arb.sv
module mwb_issue_arb
   import mwb_pkg::*;
#(
   parameter int MISS_DEPTH  = 4,
   parameter int WB_DEPTH    = 4,
   parameter int LINE_W      = 8,
   parameter int LINE_BYTES  = 64,
   parameter int ORD_W       = 8,
   parameter int MERGE_MAX   = 4,
   localparam int SIZE_W     = $clog2(LINE_BYTES) + 1,
   localparam int SLOT_W     = $clog2(MISS_DEPTH > WB_DEPTH ? MISS_DEPTH : WB_DEPTH),
   localparam int CNT_W      = $clog2(MERGE_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [LINE_W-1:0] req_line,
   input  logic              req_cach,
   input  logic              req_wr,
   input  logic              req_evict,
   input  logic [SIZE_W-1:0] req_size,
   output logic              miss_full,
   output logic              wb_full,
   output logic              line_block,
   output logic              iss_valid,
   input  logic              iss_ready,
   output logic              iss_wb,
   output logic [SLOT_W-1:0] iss_slot,
   output logic [LINE_W-1:0] iss_line,
   output logic [SIZE_W-1:0] iss_size,
   output logic [ORD_W-1:0]  iss_ord,
   output logic [CNT_W-1:0]  iss_cnt,
   output logic              iss_excl,
   input  logic              cpl_valid,
   input  logic              cpl_wb,
   input  logic [SLOT_W-1:0] cpl_slot
);
   localparam int M_IDX = $clog2(MISS_DEPTH);
   localparam int W_IDX = $clog2(WB_DEPTH);

   if (ORD_W < $clog2(MISS_DEPTH * MERGE_MAX + WB_DEPTH) + 2 || ORD_W > 30)
      begin : g_bad_ord $error("order width too small for outstanding requests"); end
   if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0)
      begin : g_bad_line $error("line size must be a power of two"); end

   logic [ORD_W-1:0]  ord_q;
   logic              to_wb, full_size, m_acc, w_acc, acc;
   logic [SIZE_W-1:0] eff_size;

   logic m_mg_ok, m_mg_cap, w_mg_ok, w_mg_cap;
   logic m_head_vld, w_head_vld, m_excl, w_excl;
   logic [M_IDX-1:0]  m_slot;
   logic [W_IDX-1:0]  w_slot;
   logic [LINE_W-1:0] m_line, w_line;
   logic [ORD_W-1:0]  m_ord, w_ord;
   logic [SIZE_W-1:0] m_size, w_size;
   logic [CNT_W-1:0]  m_cnt;
   logic              w_cnt;
   logic [MISS_DEPTH-1:0]              m_live;
   logic [MISS_DEPTH-1:0][LINE_W-1:0]  m_live_line;
   logic [MISS_DEPTH-1:0][ORD_W-1:0]   m_live_ord;
   logic [WB_DEPTH-1:0]                w_live;
   logic [WB_DEPTH-1:0][LINE_W-1:0]    w_live_line;
   logic [WB_DEPTH-1:0][ORD_W-1:0]     w_live_ord;
   logic sel_vld, sel_wb, m_pop, w_pop;

   assign to_wb     = req_evict || (req_wr && !req_cach);
   assign full_size = req_cach || req_evict;
   assign eff_size  = full_size ? SIZE_W'(LINE_BYTES) : req_size;
   assign m_acc     = req_valid && !to_wb && !m_mg_cap && (m_mg_ok || !miss_full);
   assign w_acc     = req_valid && to_wb && !w_mg_cap && !wb_full;
   assign acc       = m_acc || w_acc;
   assign line_block = req_valid && !to_wb && m_mg_cap;

   always_ff @(posedge clk) begin
      if (!rst_n)   ord_q <= '0;
      else if (acc) ord_q <= ord_q + ORD_W'(1);
   end

   mwb_slotq #(.DEPTH(MISS_DEPTH), .LINE_W(LINE_W), .ORD_W(ORD_W), .SIZE_W(SIZE_W),
               .MERGE_MAX(MERGE_MAX), .MERGE_EN(1'b1)) u_missq (
      .clk, .rst_n,
      .lk_line(req_line), .lk_cach(req_cach), .mg_ok(m_mg_ok), .mg_cap(m_mg_cap),
      .push(m_acc), .push_line(req_line), .push_ord(ord_q), .push_size(eff_size),
      .push_cach(req_cach), .push_wr(req_wr), .pop(m_pop),
      .free(cpl_valid && !cpl_wb), .free_slot(cpl_slot[M_IDX-1:0]),
      .full(miss_full), .head_vld(m_head_vld), .head_slot(m_slot), .head_line(m_line),
      .head_ord(m_ord), .head_size(m_size), .head_excl(m_excl), .head_cnt(m_cnt),
      .live(m_live), .live_line(m_live_line), .live_ord(m_live_ord));

   mwb_slotq #(.DEPTH(WB_DEPTH), .LINE_W(LINE_W), .ORD_W(ORD_W), .SIZE_W(SIZE_W),
               .MERGE_MAX(1), .MERGE_EN(1'b0)) u_wbq (
      .clk, .rst_n,
      .lk_line(req_line), .lk_cach(1'b0), .mg_ok(w_mg_ok), .mg_cap(w_mg_cap),
      .push(w_acc), .push_line(req_line), .push_ord(ord_q), .push_size(eff_size),
      .push_cach(1'b0), .push_wr(1'b1), .pop(w_pop),
      .free(cpl_valid && cpl_wb && !w_mg_ok), .free_slot(cpl_slot[W_IDX-1:0]),
      .full(wb_full), .head_vld(w_head_vld), .head_slot(w_slot), .head_line(w_line),
      .head_ord(w_ord), .head_size(w_size), .head_excl(w_excl), .head_cnt(w_cnt),
      .live(w_live), .live_line(w_live_line), .live_ord(w_live_ord));

   mwb_pick #(.M_DEPTH(MISS_DEPTH), .W_DEPTH(WB_DEPTH), .LINE_W(LINE_W), .ORD_W(ORD_W)) u_pick (
      .clk, .rst_n,
      .m_head_vld, .m_head_line(m_line), .m_head_ord(m_ord),
      .m_live, .m_live_line, .m_live_ord,
      .w_head_vld, .w_head_line(w_line), .w_head_ord(w_ord),
      .w_live, .w_live_line, .w_live_ord,
      .w_full(wb_full), .sel_vld, .sel_wb);

   assign iss_valid = sel_vld;
   assign iss_wb    = sel_wb;
   assign m_pop     = sel_vld && !sel_wb && iss_ready;
   assign w_pop     = sel_vld && sel_wb && iss_ready;
   assign iss_slot  = sel_wb ? SLOT_W'(w_slot) : SLOT_W'(m_slot);
   assign iss_line  = sel_wb ? w_line : m_line;
   assign iss_size  = sel_wb ? w_size : m_size;
   assign iss_ord   = sel_wb ? w_ord  : m_ord;
   assign iss_cnt   = sel_wb ? CNT_W'(w_cnt) : m_cnt;
   assign iss_excl  = sel_wb ? w_excl : m_excl;

   // R1
   ord_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> ord_q == $past(ord_q) + ORD_W'(1));
   // R1
   ord_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(ord_q));
   // R7
   block_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_block |-> !m_acc && !w_acc);
endmodule

// File: tb/mwb_issue_arb_tb.sv
`timescale 1ns/1ps
module mwb_issue_arb_tb;
   localparam int LW = 4, LB = 8, OW = 6, MM = 2;
   localparam int SW = 4, SLW = 2, CW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_cach = 0, req_wr = 0, req_evict = 0;
   logic [LW-1:0] req_line = '0;
   logic [SW-1:0] req_size = '0;
   logic miss_full, wb_full, line_block, iss_valid, iss_wb, iss_excl;
   logic iss_ready = 0, cpl_valid = 0, cpl_wb = 0;
   logic [SLW-1:0] iss_slot, cpl_slot = '0;
   logic [LW-1:0]  iss_line;
   logic [SW-1:0]  iss_size;
   logic [OW-1:0]  iss_ord;
   logic [CW-1:0]  iss_cnt;

   int n_chk = 0, n_bad = 0, exp_ord = 0;
   int last_slot, blk_seen;
   int held_slot[4];

   always #4 clk = ~clk;

   mwb_issue_arb #(.MISS_DEPTH(4), .WB_DEPTH(2), .LINE_W(LW), .LINE_BYTES(LB),
                   .ORD_W(OW), .MERGE_MAX(MM)) u_dut (.*);

   task automatic chk(input string r, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   task automatic put(input int line, input bit c, input bit w, input bit ev,
                      input int sz, input bit exp_acc);
      @(negedge clk);
      req_valid = 1; req_line = LW'(line); req_cach = c; req_wr = w;
      req_evict = ev; req_size = SW'(sz);
      #1 blk_seen = int'(line_block);
      @(posedge clk); #1 req_valid = 0;
      if (exp_acc) exp_ord++;
   endtask

   task automatic take(input string r, input bit wb, input int line, input int sz,
                       input int ord, input int cnt, input bit ex);
      @(negedge clk); #1;
      chk({r, " valid"}, int'(iss_valid), 1);
      chk({r, " queue"}, int'(iss_wb), int'(wb));
      chk({r, " line"}, int'(iss_line), line);
      chk({r, " size"}, int'(iss_size), sz);
      chk({r, " order"}, int'(iss_ord), ord % 64);
      chk({r, " count"}, int'(iss_cnt), cnt);
      chk({r, " excl"}, int'(iss_excl), int'(ex));
      last_slot = int'(iss_slot);
      iss_ready = 1;
      @(posedge clk); #1 iss_ready = 0;
   endtask

   task automatic fin(input bit wb, input int slot);
      @(negedge clk);
      cpl_valid = 1; cpl_wb = wb; cpl_slot = SLW'(slot);
      @(posedge clk); #1 cpl_valid = 0;
   endtask

   task automatic idle(input string r);
      @(negedge clk); #1 chk({r, " idle"}, int'(iss_valid), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int a;
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      chk("R10 iss_valid", int'(iss_valid), 0);
      chk("R10 miss_full", int'(miss_full), 0);
      chk("R10 wb_full", int'(wb_full), 0);
      chk("R10 line_block", int'(line_block), 0);
      @(negedge clk) rst_n = 1;
      idle("R10");

      // R6 / R1 sweep: every byte count, both memory kinds
      for (int c = 0; c < 2; c++) begin
         for (int s = 1; s <= LB; s++) begin
            a = exp_ord;
            put(s, c[0], 0, 0, s, 1);
            take("R6 size sweep", 0, s, c ? LB : s, a, 1, 0);
            fin(0, last_slot);
         end
      end

      // R2 / R7 merge depth sweep: k requests on one line, odd ones are writes
      for (int k = 1; k <= MM + 1; k++) begin
         a = exp_ord;
         for (int i = 0; i < k; i++) begin
            put(4 + k, 1, i[0], 0, 1, i < MM);
            chk("R7 line_block", blk_seen, int'(i >= MM));
         end
         take("R2 merge", 0, 4 + k, LB, a, (k < MM) ? k : MM, k >= 2);
         fin(0, last_slot);
         idle("R7 refused not issued");
      end
      // R7 refused request consumed no order number
      a = exp_ord;
      put(1, 0, 0, 0, 2, 1);
      take("R7 R1 order after refuse", 0, 1, 2, a, 1, 0);
      fin(0, last_slot);

      // R2 request after issue opens new entry
      a = exp_ord;
      put(7, 1, 0, 0, 1, 1);
      take("R2 first", 0, 7, LB, a, 1, 0);
      held_slot[0] = last_slot;
      put(7, 1, 1, 0, 1, 1);
      take("R2 after issue", 0, 7, LB, a + 1, 1, 1);
      fin(0, held_slot[0]);
      fin(0, last_slot);

      // R4 read first when write queue not full
      a = exp_ord;
      put(1, 0, 1, 0, 1, 1);
      put(2, 0, 0, 0, 1, 1);
      take("R4 read first", 0, 2, 1, a + 1, 1, 0);
      fin(0, last_slot);
      take("R4 then write", 1, 1, 1, a, 1, 1);
      fin(1, last_slot);
      // R4 write first when write queue full
      a = exp_ord;
      put(3, 0, 1, 0, 2, 1);
      put(4, 0, 1, 0, 4, 1);
      put(9, 0, 0, 0, 1, 1);
      @(negedge clk); #1 chk("R8 wb_full", int'(wb_full), 1);
      take("R4 full write first", 1, 3, 2, a, 1, 1);
      fin(1, last_slot);
      take("R4 read after", 0, 9, 1, a + 2, 1, 0);
      fin(0, last_slot);
      take("R3 write order", 1, 4, 4, a + 1, 1, 1);
      fin(1, last_slot);

      // R5 older write blocks same-line read
      a = exp_ord;
      put(8, 0, 1, 0, 1, 1);
      put(8, 1, 0, 0, 1, 1);
      take("R5 older write", 1, 8, 1, a, 1, 1);
      fin(1, last_slot);
      take("R5 read after", 0, 8, LB, a + 1, 1, 0);
      fin(0, last_slot);
      // R5 older read beats full write queue on same line
      a = exp_ord;
      put(10, 0, 0, 0, 2, 1);
      put(10, 0, 1, 0, 1, 1);
      put(11, 0, 1, 0, 4, 1);
      take("R5 older read", 0, 10, 2, a, 1, 0);
      fin(0, last_slot);
      take("R5 write line", 1, 10, 1, a + 1, 1, 1);
      fin(1, last_slot);
      take("R5 write two", 1, 11, 4, a + 2, 1, 1);
      fin(1, last_slot);

      // R8 / R9 read queue full
      a = exp_ord;
      for (int i = 0; i < 4; i++) put(i, 0, 0, 0, 1, 1);
      @(negedge clk); #1 chk("R8 miss_full", int'(miss_full), 1);
      put(12, 0, 0, 0, 1, 0);
      for (int i = 0; i < 4; i++) begin
         take("R3 R8 drain", 0, i, 1, a + i, 1, 0);
         held_slot[i] = last_slot;
      end
      idle("R8 refused");
      @(negedge clk); #1 chk("R9 full until completion", int'(miss_full), 1);
      fin(0, held_slot[2]);
      @(negedge clk); #1 chk("R9 freed", int'(miss_full), 0);
      fin(0, held_slot[0]); fin(0, held_slot[1]); fin(0, held_slot[3]);
      // R8 write queue full with evictions (full line size)
      a = exp_ord;
      put(5, 1, 1, 1, 1, 1);
      put(6, 1, 1, 1, 1, 1);
      put(13, 1, 1, 1, 1, 0);
      take("R10 R6 evict", 1, 5, LB, a, 1, 1);
      fin(1, last_slot);
      take("R10 R6 evict two", 1, 6, LB, a + 1, 1, 1);
      fin(1, last_slot);
      idle("R8 wb refused");
      @(negedge clk); #1 chk("R9 wb_full clear", int'(wb_full), 0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule